// File: doc/BRIEF.md
# Tiled Surface Copy Address Walker

This block generates the addresses for a copy between a linear (row-major) raster and a tiled surface. The tiled surface is made of 16x16-element tiles, and the elements inside each tile are reordered by a bit interleave. A start request latches a rectangle: its origin in the tiled surface, its width and height in elements, a byte stride for each side and an element-size shift. The block then visits the rectangle row by row, left to right within each row. For every element it produces one address pair on a valid/ready stream.

Each pair holds a source address and a destination address. In store direction the source is the linear address and the destination is the tiled address; load direction swaps them. The linear address is relative to the start of the region. The tiled address is relative to the base of the tiled surface.

Inside a tile, the y-dependent half of the swizzle is the low four y bits with each bit doubled. It is computed once at the start of each row and held in a register. Each element then only XORs in its own spread-out x bits. A one-cycle done pulse closes every request.

Top module: `tw_walker`

## Requirements
- R1: A start request while idle with nonzero width and height latches all inputs, and valid_o is high in the next cycle. Inputs changed after that cycle have no effect on the pairs.
- R2: Exactly width*height pairs are emitted, row by row from row 0 and left to right within a row. The linear address of element (row r, column c) is r*lin_stride + (c << shift).
- R3: For an element at surface coordinates (x, y), the tiled address is ((y & ~15) * tile_stride) + ((((x >> 4) << 8) | idx) << shift). Here idx bit 2k+1 is y bit k, and idx bit 2k is x bit k XOR y bit k, for k = 0..3.
- R4: When the origin x is a multiple of 16, the tiled address at column c+16 of a row exceeds the one at column c by exactly 256 << shift.
- R5: With store_i = 1, src_addr_o is the linear address and dst_addr_o is the tiled address. With store_i = 0 the two are swapped. store_o reports the latched direction while valid_o is high.
- R6: While valid_o is high and ready_i is low, valid_o stays high and both addresses stay stable.
- R7: done_o is high for one cycle, in the cycle after the last pair is accepted, and valid_o is low while done_o is high.
- R8: A start request while pairs are still being emitted is ignored. The running sequence continues unchanged.
- R9: A start request with width or height equal to zero emits no pairs, and done_o is high in the next cycle.
- R10: After reset, valid_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled only while idle |
| store_i | input | 1 | 1: linear to tiled, 0: tiled to linear |
| org_x_i | input | COORD_W | Region origin x in the tiled surface, in elements |
| org_y_i | input | COORD_W | Region origin y in the tiled surface, in elements |
| width_i | input | COORD_W | Region width in elements |
| height_i | input | COORD_W | Region height in elements |
| lin_stride_i | input | ADDR_W | Byte distance between linear rows |
| tile_stride_i | input | ADDR_W | Byte size of one element row of the tiled surface; a band of tiles spans 16 of these |
| elem_shift_i | input | SHIFT_W | log2 of element size in bytes (0..4) |
| valid_o | output | 1 | Address pair valid |
| ready_i | input | 1 | Consumer accepts the pair |
| src_addr_o | output | ADDR_W | Source byte address |
| dst_addr_o | output | ADDR_W | Destination byte address |
| store_o | output | 1 | Direction of the current pair |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at tile-boundary crossings in both axes. A row that crosses y = 15 -> 16 must reload the y term and step the band base; a walker that failed to reload would scramble every element after the first row. Regions that start mid-tile in x catch a design that steps the tile pointer on a count of 16 columns instead of on the x coordinate. Zero-sized regions and start pulses sent while busy test the control path: a faulty design would emit stray pairs or restart with the new region. Consumer stalls at random points check that a pair is never skipped or repeated.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tw_state_e;

  // y3 y3 y2 y2 y1 y1 y0 y0
  function automatic logic [7:0] dup_bits(input logic [3:0] v);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) begin
      r[2*i]   = v[i];
      r[2*i+1] = v[i];
    end
    return r;
  endfunction

  // 0 x3 0 x2 0 x1 0 x0
  function automatic logic [7:0] spread_bits(input logic [3:0] v);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) begin
      r[2*i]   = v[i];
      r[2*i+1] = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/tw_row_term.sv
module tw_row_term (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [3:0] y_low_i,
  output logic [7:0] term_o
);
  import tw_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     term_o <= '0;
    else if (load_i) term_o <= dup_bits(y_low_i);
  end
endmodule

// File: rtl/tw_swizzle.sv
module tw_swizzle (
  input  logic [7:0] y_term_i,
  input  logic [3:0] x_low_i,
  output logic [7:0] idx_o
);
  import tw_pkg::*;

  assign idx_o = y_term_i ^ spread_bits(x_low_i);
endmodule

// File: rtl/tw_dir_mux.sv
module tw_dir_mux #(
  parameter int ADDR_W = 32
) (
  input  logic              store_i,
  input  logic [ADDR_W-1:0] lin_addr_i,
  input  logic [ADDR_W-1:0] tile_addr_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o
);
  assign src_addr_o = store_i ? lin_addr_i  : tile_addr_i;
  assign dst_addr_o = store_i ? tile_addr_i : lin_addr_i;
endmodule

// File: rtl/tw_walker.sv
module tw_walker #(
  parameter int COORD_W = 16,
  parameter int ADDR_W  = 32,
  parameter int SHIFT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               store_i,
  input  logic [COORD_W-1:0] org_x_i,
  input  logic [COORD_W-1:0] org_y_i,
  input  logic [COORD_W-1:0] width_i,
  input  logic [COORD_W-1:0] height_i,
  input  logic [ADDR_W-1:0]  lin_stride_i,
  input  logic [ADDR_W-1:0]  tile_stride_i,
  input  logic [SHIFT_W-1:0] elem_shift_i,
  output logic               valid_o,
  input  logic               ready_i,
  output logic [ADDR_W-1:0]  src_addr_o,
  output logic [ADDR_W-1:0]  dst_addr_o,
  output logic               store_o,
  output logic               done_o
);
  import tw_pkg::*;

  localparam int TX_W   = COORD_W - 4;
  localparam int TIDX_W = TX_W + 8;

  tw_state_e          st_q;
  logic [COORD_W-1:0] w_q, h_q, org_x_q;
  logic [COORD_W-1:0] col_q, row_q, cur_x_q, cur_y_q;
  logic [ADDR_W-1:0]  lin_stride_q, tile_stride_q;
  logic [ADDR_W-1:0]  lin_row_q, lin_addr_q, band_base_q;
  logic [SHIFT_W-1:0] shift_q;
  logic               store_q, done_q;

  logic               idle, accept, last_col, last_row, zero_reg;
  logic               term_load;
  logic [3:0]         term_y;
  logic [7:0]         y_term, idx;
  logic [COORD_W-1:0] next_y;
  logic [ADDR_W-1:0]  start_band, tile_addr, tile_off;
  logic [TIDX_W-1:0]  tile_idx;

  assign idle     = (st_q == ST_IDLE);
  assign accept   = (st_q == ST_RUN) && ready_i;
  assign last_col = (col_q == w_q - COORD_W'(1));
  assign last_row = (row_q == h_q - COORD_W'(1));
  assign zero_reg = (width_i == '0) || (height_i == '0);
  assign next_y   = cur_y_q + COORD_W'(1);

  assign start_band = (ADDR_W'(org_y_i) & ~ADDR_W'(15)) * tile_stride_i;

  // y half of the swizzle: reloaded only at region start and at row change
  assign term_load = (idle && start_i) || (accept && last_col && !last_row);
  assign term_y    = idle ? org_y_i[3:0] : next_y[3:0];

  tw_row_term u_row_term (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (term_load),
    .y_low_i (term_y),
    .term_o  (y_term)
  );

  tw_swizzle u_swizzle (
    .y_term_i (y_term),
    .x_low_i  (cur_x_q[3:0]),
    .idx_o    (idx)
  );

  assign tile_idx  = {cur_x_q[COORD_W-1:4], idx};
  assign tile_off  = ADDR_W'(tile_idx) << shift_q;
  assign tile_addr = band_base_q + tile_off;

  tw_dir_mux #(.ADDR_W(ADDR_W)) u_dir_mux (
    .store_i     (store_q),
    .lin_addr_i  (lin_addr_q),
    .tile_addr_i (tile_addr),
    .src_addr_o  (src_addr_o),
    .dst_addr_o  (dst_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      w_q           <= '0;
      h_q           <= '0;
      org_x_q       <= '0;
      col_q         <= '0;
      row_q         <= '0;
      cur_x_q       <= '0;
      cur_y_q       <= '0;
      lin_stride_q  <= '0;
      tile_stride_q <= '0;
      lin_row_q     <= '0;
      lin_addr_q    <= '0;
      band_base_q   <= '0;
      shift_q       <= '0;
      store_q       <= 1'b0;
      done_q        <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            w_q           <= width_i;
            h_q           <= height_i;
            org_x_q       <= org_x_i;
            col_q         <= '0;
            row_q         <= '0;
            cur_x_q       <= org_x_i;
            cur_y_q       <= org_y_i;
            lin_stride_q  <= lin_stride_i;
            tile_stride_q <= tile_stride_i;
            lin_row_q     <= '0;
            lin_addr_q    <= '0;
            band_base_q   <= start_band;
            shift_q       <= elem_shift_i;
            store_q       <= store_i;
            if (zero_reg) done_q <= 1'b1;
            else          st_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (ready_i) begin
            if (last_col) begin
              if (last_row) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                row_q      <= row_q + COORD_W'(1);
                col_q      <= '0;
                cur_x_q    <= org_x_q;
                cur_y_q    <= next_y;
                lin_row_q  <= lin_row_q + lin_stride_q;
                lin_addr_q <= lin_row_q + lin_stride_q;
                if (cur_y_q[3:0] == 4'hf)
                  band_base_q <= band_base_q + (tile_stride_q << 4);
              end
            end else begin
              col_q      <= col_q + COORD_W'(1);
              cur_x_q    <= cur_x_q + COORD_W'(1);
              lin_addr_q <= lin_addr_q + (ADDR_W'(1) << shift_q);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign valid_o = (st_q == ST_RUN);
  assign store_o = store_q;
  assign done_o  = done_q;

endmodule

// File: rtl/tw_walker_chk.sv
module tw_walker_chk #(
  parameter int COORD_W = 16,
  parameter int ADDR_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [COORD_W-1:0] width_i,
  input logic [COORD_W-1:0] height_i,
  input logic               valid_o,
  input logic               ready_i,
  input logic [ADDR_W-1:0]  src_addr_o,
  input logic [ADDR_W-1:0]  dst_addr_o,
  input logic               done_o
);
  logic zero_in;
  assign zero_in = (width_i == '0) || (height_i == '0);

  a_r1_start_to_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !valid_o && !zero_in |=> valid_o);

  a_r6_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(src_addr_o) && $stable(dst_addr_o));

  a_r7_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);

  a_r7_done_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(valid_o && ready_i) || $past(start_i && !valid_o));

  a_r9_zero_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !valid_o && zero_in |=> done_o && !valid_o);

  a_r8_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && start_i |=> valid_o);

endmodule

bind tw_walker tw_walker_chk #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .width_i    (width_i),
  .height_i   (height_i),
  .valid_o    (valid_o),
  .ready_i    (ready_i),
  .src_addr_o (src_addr_o),
  .dst_addr_o (dst_addr_o),
  .done_o     (done_o)
);

// File: tb/tb_tw_walker.sv
module tb_tw_walker;
  localparam int COORD_W = 16;
  localparam int ADDR_W  = 32;
  localparam int SHIFT_W = 3;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               start_i = 1'b0, store_i = 1'b0, ready_i = 1'b0;
  logic [COORD_W-1:0] org_x_i = '0, org_y_i = '0, width_i = '0, height_i = '0;
  logic [ADDR_W-1:0]  lin_stride_i = '0, tile_stride_i = '0;
  logic [SHIFT_W-1:0] elem_shift_i = '0;
  logic               valid_o, store_o, done_o;
  logic [ADDR_W-1:0]  src_addr_o, dst_addr_o;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  tw_walker #(.COORD_W(COORD_W), .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i), .store_i (store_i),
    .org_x_i (org_x_i), .org_y_i (org_y_i), .width_i (width_i), .height_i (height_i),
    .lin_stride_i (lin_stride_i), .tile_stride_i (tile_stride_i),
    .elem_shift_i (elem_shift_i), .valid_o (valid_o), .ready_i (ready_i),
    .src_addr_o (src_addr_o), .dst_addr_o (dst_addr_o), .store_o (store_o),
    .done_o (done_o)
  );

  function automatic longint unsigned exp_tile(longint x, longint y, longint ts, int sh);
    longint idx = 0;
    for (int b = 0; b < 4; b++) begin
      idx |= (((x >> b) & 1) ^ ((y >> b) & 1)) << (2*b);
      idx |= ((y >> b) & 1) << (2*b + 1);
    end
    return ((y & ~longint'(15)) * ts + ((((x >> 4) << 8) | idx) << sh)) & 64'hFFFF_FFFF;
  endfunction

  function automatic longint unsigned exp_lin(longint r, longint c, longint ls, int sh);
    return (r * ls + (c << sh)) & 64'hFFFF_FFFF;
  endfunction

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input bit st, input int x, input int y, input int w, input int h,
                     input int ls, input int ts, input int sh, input bit poke);
    int k = 0;
    int guard = 0;
    bit seen_done = 0;
    int total = w * h;
    longint unsigned seg_tile = 0;
    @(negedge clk);
    store_i = st; org_x_i = COORD_W'(x); org_y_i = COORD_W'(y);
    width_i = COORD_W'(w); height_i = COORD_W'(h);
    lin_stride_i = ADDR_W'(ls); tile_stride_i = ADDR_W'(ts);
    elem_shift_i = SHIFT_W'(sh); start_i = 1'b1; ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    // R1: scramble inputs after the start has been taken
    store_i = ~st; org_x_i = COORD_W'($urandom); org_y_i = COORD_W'($urandom);
    width_i = COORD_W'(3); height_i = COORD_W'(2);
    lin_stride_i = ADDR_W'($urandom); tile_stride_i = ADDR_W'($urandom);
    elem_shift_i = SHIFT_W'($urandom);
    if (total == 0)
      check(done_o && !valid_o, "R9 zero region done next cycle", {done_o, valid_o}, 2'b10);
    while (!seen_done && guard < 20000) begin
      if (done_o) begin
        seen_done = 1;
        check(!valid_o, "R7 valid low with done", valid_o, 0);
      end else begin
        start_i = 1'b0;
        if (valid_o) begin
          bit r = ($urandom % 4) != 0;
          ready_i = r;
          if (r) begin
            int c = k % w;
            int rw = k / w;
            longint unsigned el = exp_lin(rw, c, ls, sh);
            longint unsigned et = exp_tile(x + c, y + rw, ts, sh);
            longint unsigned es = st ? el : et;
            longint unsigned ed = st ? et : el;
            check(k < total, "R2 pair count", k, total);
            check(src_addr_o == ADDR_W'(es) && dst_addr_o == ADDR_W'(ed) && store_o == st,
                  st ? "R3/R5 store pair" : "R3/R5 load pair",
                  {src_addr_o, dst_addr_o}, {es[31:0], ed[31:0]});
            if ((x % 16) == 0 && (c % 16) == 0) begin
              if (c > 0)
                check(et - seg_tile == (longint'(256) << sh), "R4 tile step",
                      et - seg_tile, longint'(256) << sh);
              seg_tile = et;
            end
            k++;
          end
          if (poke && k == 3 && total > 6) begin
            start_i = 1'b1; // R8: ignored while busy
            width_i = COORD_W'(1); height_i = COORD_W'(1);
          end
        end else ready_i = 1'b0;
        @(negedge clk);
        guard++;
      end
    end
    start_i = 1'b0; ready_i = 1'b0;
    check(seen_done && k == total, "R2/R7/R8 done after all pairs", k, total);
    @(negedge clk);
    check(!done_o, "R7 done single cycle", done_o, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!valid_o && !done_o, "R10 reset state", {valid_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!valid_o && !done_o, "R10 idle after reset", {valid_o, done_o}, 0);
    run(1, 16, 0, 48, 3, 200, 256, 2, 0);   // R4 aligned store
    run(0, 16, 0, 48, 3, 200, 256, 2, 0);   // R5 load direction
    run(1, 5, 3, 0, 4, 64, 128, 1, 0);      // R9 w=0
    run(1, 5, 3, 7, 0, 64, 128, 1, 0);      // R9 h=0
    run(1, 9, 9, 1, 1, 16, 64, 0, 0);       // single element
    run(0, 3, 14, 20, 4, 100, 96, 3, 0);    // R3 band crossing
    run(1, 32, 30, 16, 5, 300, 512, 4, 1);  // R8 busy start
    for (int i = 0; i < 25; i++) begin
      int w  = 1 + ($urandom % 40);
      int sh = $urandom % 5;
      run($urandom % 2, $urandom % 64, $urandom % 64, w, 1 + ($urandom % 6),
          (w << sh) + ($urandom % 64), 64 + ($urandom % 960), sh, $urandom % 2);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule